// File: doc/BRIEF.md
# Modulo Circular Buffer Address Generator

This block computes physical addresses into a single shared sample memory that holds the delay lines of several filters side by side. Each word of that memory holds one I/Q pair, and the memory is 384 words deep by default. Every filter owns one contiguous region of the memory. The region has a programmable start address and a programmable power-of-2 length. Inside its region, a filter's write pointer and its tap read pointers wrap by masking to the region length, so a delay line never needs its samples moved.

A sequencer chooses a filter and asks for one or both of two things in the same cycle. A write address is where the next input sample goes, and that write advances the filter's pointer. Two tap read addresses are placed at given offsets behind the write pointer, so the newest and the oldest mirrored samples of a symmetric filter can be fetched together. Region geometry is loaded one filter at a time. A geometry that does not fit in the memory is flagged, and a flagged filter is not served. The memory array, the arbitration between filters and the arithmetic datapath sit outside this block.

Top module: `circbuf_addr_gen`

## Requirements
- R1: After synchronous reset, `wr_addr_valid` and `rd_addr_valid` are 0, `err_vec` is all zero, and every filter has base 0, length exponent 0 and pointer 0.
- R2: A write request to a filter that is not flagged gives, one cycle later, `wr_addr_valid`=1 and `wr_addr` = base + (pointer AND (2^exp − 1)). The pointer then advances by one.
- R3: Write addresses wrap. After 2^exp writes, a filter's write address returns to its base.
- R4: A read request to a filter that is not flagged gives, one cycle later, `rd_addr_valid`=1 and each tap address = base + ((pointer − offset) AND (2^exp − 1)). Offset 1 selects the most recently written sample. Offsets of the region length or more wrap the same way.
- R5: The two tap ports use independent offsets in the same cycle.
- R6: When a write and a read reach the same filter in one cycle, the read uses the pointer value from before that write.
- R7: Requests to one filter never move the pointer of another filter.
- R8: A configuration write (`cfg_we`=1) loads base and exponent for filter `cfg_sel` and clears its pointer to 0. If a write request to that filter arrives in the same cycle, the clear wins, and that request's address is still formed from the previous geometry.
- R9: `err_vec[f]` is set one cycle after a configuration write to filter f whose exponent exceeds 8 or whose base + 2^exp exceeds 384. A later valid configuration of f clears it. Only configuration writes change `err_vec`.
- R10: A write or read request to a filter whose `err_vec` bit is 1 gives no valid output and does not advance that filter's pointer.
- R11: A region of exponent 0 (length 1) returns its base for every write and tap address.
- R12: A 256-word region that ends exactly at word 383 is accepted, and its last write address is 383. The same region moved up by one word is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load geometry for filter `cfg_sel` |
| cfg_sel | input | 2 | Filter whose geometry is loaded |
| cfg_base | input | 9 | Region start address |
| cfg_log2 | input | 4 | Region length exponent (length = 2^value) |
| req_sel | input | 2 | Filter addressed by this cycle's requests |
| wr_req | input | 1 | Request a write address and advance the pointer |
| rd_req | input | 1 | Request both tap read addresses |
| tap_off_a | input | 8 | Offset behind the write pointer for tap port A |
| tap_off_b | input | 8 | Offset behind the write pointer for tap port B |
| wr_addr_valid | output | 1 | `wr_addr` holds a served write address |
| wr_addr | output | 9 | Physical write address |
| rd_addr_valid | output | 1 | Tap addresses hold served read addresses |
| rd_addr_a | output | 9 | Physical read address, tap port A |
| rd_addr_b | output | 9 | Physical read address, tap port B |
| err_vec | output | 4 | Per-filter flag for a geometry that does not fit |

## Verification
The hardest corner to reach is the top edge of the memory. A full 256-word region must be pushed through all of its pointer values before its last address, 383, appears. The bench does this by streaming 256 consecutive writes into a region based at 128, and every one of those addresses is checked. Two other cases need exact timing. In one, a configuration write and a write request land on the same filter in the same cycle. In the other, a filter is flagged and then requested. For both, the bench lines up the configuration and request inputs on the same clock edge and then watches where the next write lands.

// File: rtl/circbuf_pkg.sv
package circbuf_pkg;
  localparam int unsigned DEF_MEM_DEPTH = 384;
  localparam int unsigned DEF_MAX_LOG2  = 8;
  localparam int unsigned DEF_NUM_FILT  = 4;
  // address ports computed each cycle: write, tap A, tap B
  localparam int unsigned NUM_PORTS     = 3;
  localparam int unsigned PORT_WR       = 0;
  localparam int unsigned PORT_TAP_A    = 1;
  localparam int unsigned PORT_TAP_B    = 2;
endpackage

// File: rtl/circbuf_cfg_regs.sv
module circbuf_cfg_regs #(
  parameter int unsigned NUM_FILT  = 4,
  parameter int unsigned MEM_DEPTH = 384,
  parameter int unsigned MAX_LOG2  = 8,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned LOG2_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LOG2_W-1:0] cfg_log2,
  output logic [ADDR_W-1:0] base_o [NUM_FILT],
  output logic [LOG2_W-1:0] log2_o [NUM_FILT],
  output logic [NUM_FILT-1:0] err_o,
  output logic [NUM_FILT-1:0] clr_o
);
  logic [31:0] span;
  logic        bad_cfg;

  always_comb begin
    span    = 32'(cfg_base) + (32'd1 << cfg_log2);
    bad_cfg = (32'(cfg_log2) > 32'(MAX_LOG2)) || (span > 32'(MEM_DEPTH));
  end

  for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
    logic hit;
    assign hit      = cfg_we && (cfg_sel == SEL_W'(f));
    assign clr_o[f] = hit;

    always_ff @(posedge clk) begin
      if (rst) begin
        base_o[f] <= '0;
        log2_o[f] <= '0;
        err_o[f]  <= 1'b0;
      end else if (hit) begin
        base_o[f] <= cfg_base;
        log2_o[f] <= cfg_log2;
        err_o[f]  <= bad_cfg;
      end
    end
  end
endmodule

// File: rtl/circbuf_ptr_bank.sv
module circbuf_ptr_bank #(
  parameter int unsigned NUM_FILT = 4,
  parameter int unsigned PTR_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_FILT-1:0] clr,
  input  logic [NUM_FILT-1:0] adv,
  output logic [PTR_W-1:0]    wp_o [NUM_FILT]
);
  for (genvar f = 0; f < NUM_FILT; f++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)          wp_o[f] <= '0;
      else if (clr[f])  wp_o[f] <= '0;
      else if (adv[f])  wp_o[f] <= wp_o[f] + PTR_W'(1);
    end
  end
endmodule

// File: rtl/circbuf_addr_calc.sv
module circbuf_addr_calc #(
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LOG2_W = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [LOG2_W-1:0] log2,
  input  logic [PTR_W-1:0]  ptr,
  output logic [ADDR_W-1:0] addr
);
  logic [PTR_W:0]   mask_wide;
  logic [PTR_W-1:0] offs;

  always_comb begin
    mask_wide = ((PTR_W+1)'(1) << log2) - (PTR_W+1)'(1);
    offs      = ptr & mask_wide[PTR_W-1:0];
    addr      = base + ADDR_W'(offs);
  end
endmodule

// File: rtl/circbuf_addr_gen.sv
module circbuf_addr_gen #(
  parameter int unsigned NUM_FILT  = circbuf_pkg::DEF_NUM_FILT,
  parameter int unsigned MEM_DEPTH = circbuf_pkg::DEF_MEM_DEPTH,
  parameter int unsigned MAX_LOG2  = circbuf_pkg::DEF_MAX_LOG2,
  localparam int unsigned SEL_W    = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1,
  localparam int unsigned ADDR_W   = $clog2(MEM_DEPTH),
  localparam int unsigned PTR_W    = MAX_LOG2,
  localparam int unsigned LOG2_W   = $clog2(MAX_LOG2 + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [LOG2_W-1:0]   cfg_log2,
  input  logic [SEL_W-1:0]    req_sel,
  input  logic                wr_req,
  input  logic                rd_req,
  input  logic [PTR_W-1:0]    tap_off_a,
  input  logic [PTR_W-1:0]    tap_off_b,
  output logic                wr_addr_valid,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic                rd_addr_valid,
  output logic [ADDR_W-1:0]   rd_addr_a,
  output logic [ADDR_W-1:0]   rd_addr_b,
  output logic [NUM_FILT-1:0] err_vec
);
  import circbuf_pkg::*;

  logic [ADDR_W-1:0]   base_a [NUM_FILT];
  logic [LOG2_W-1:0]   log2_a [NUM_FILT];
  logic [NUM_FILT-1:0] err_a;
  logic [NUM_FILT-1:0] clr_a;
  logic [NUM_FILT-1:0] adv_a;
  logic [PTR_W-1:0]    wp_a [NUM_FILT];

  logic [ADDR_W-1:0]   base_sel;
  logic [LOG2_W-1:0]   log2_sel;
  logic [PTR_W-1:0]    wp_sel;
  logic                sel_ok;
  logic [PTR_W-1:0]    port_ptr  [NUM_PORTS];
  logic [ADDR_W-1:0]   port_addr [NUM_PORTS];

  circbuf_cfg_regs #(
    .NUM_FILT(NUM_FILT), .MEM_DEPTH(MEM_DEPTH), .MAX_LOG2(MAX_LOG2),
    .SEL_W(SEL_W), .ADDR_W(ADDR_W), .LOG2_W(LOG2_W)
  ) i_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_base(cfg_base), .cfg_log2(cfg_log2),
    .base_o(base_a), .log2_o(log2_a), .err_o(err_a), .clr_o(clr_a)
  );

  circbuf_ptr_bank #(.NUM_FILT(NUM_FILT), .PTR_W(PTR_W)) i_ptr (
    .clk(clk), .rst(rst), .clr(clr_a), .adv(adv_a), .wp_o(wp_a)
  );

  always_comb begin
    base_sel = base_a[req_sel];
    log2_sel = log2_a[req_sel];
    wp_sel   = wp_a[req_sel];
    sel_ok   = !err_a[req_sel];
    port_ptr[PORT_WR]    = wp_sel;
    port_ptr[PORT_TAP_A] = wp_sel - tap_off_a;
    port_ptr[PORT_TAP_B] = wp_sel - tap_off_b;
  end

  for (genvar f = 0; f < NUM_FILT; f++) begin : g_adv
    assign adv_a[f] = wr_req && sel_ok && (req_sel == SEL_W'(f));
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    circbuf_addr_calc #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .LOG2_W(LOG2_W)) i_calc (
      .base(base_sel), .log2(log2_sel), .ptr(port_ptr[p]), .addr(port_addr[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr_valid <= 1'b0;
      rd_addr_valid <= 1'b0;
      wr_addr       <= '0;
      rd_addr_a     <= '0;
      rd_addr_b     <= '0;
    end else begin
      wr_addr_valid <= wr_req && sel_ok;
      rd_addr_valid <= rd_req && sel_ok;
      wr_addr       <= port_addr[PORT_WR];
      rd_addr_a     <= port_addr[PORT_TAP_A];
      rd_addr_b     <= port_addr[PORT_TAP_B];
    end
  end

  assign err_vec = err_a;
endmodule

// File: rtl/circbuf_addr_gen_chk.sv
module circbuf_addr_gen_chk #(
  parameter int unsigned NUM_FILT  = 4,
  parameter int unsigned MEM_DEPTH = 384,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned ADDR_W    = 9
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_we,
  input logic [SEL_W-1:0]    req_sel,
  input logic                wr_req,
  input logic                rd_req,
  input logic                wr_addr_valid,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic                rd_addr_valid,
  input logic [ADDR_W-1:0]   rd_addr_a,
  input logic [ADDR_W-1:0]   rd_addr_b,
  input logic [NUM_FILT-1:0] err_vec
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wr_addr_valid && !rd_addr_valid && err_vec == '0)); // R1
  AST_WR_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    wr_addr_valid |-> $past(wr_req)); // R2
  AST_WR_IN_MEM: assert property (@(posedge clk) disable iff (rst)
    wr_addr_valid |-> (32'(wr_addr) < 32'(MEM_DEPTH))); // R12
  AST_RD_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    rd_addr_valid |-> $past(rd_req)); // R4
  AST_RD_IN_MEM: assert property (@(posedge clk) disable iff (rst)
    rd_addr_valid |-> (32'(rd_addr_a) < 32'(MEM_DEPTH) && 32'(rd_addr_b) < 32'(MEM_DEPTH))); // R4
  AST_ERR_ONLY_CFG: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(err_vec)); // R9
  AST_FLAGGED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (wr_addr_valid || rd_addr_valid) |-> ($past(err_vec[req_sel]) == 1'b0)); // R10
endmodule

bind circbuf_addr_gen circbuf_addr_gen_chk #(
  .NUM_FILT(NUM_FILT), .MEM_DEPTH(MEM_DEPTH), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .req_sel(req_sel), .wr_req(wr_req),
  .rd_req(rd_req), .wr_addr_valid(wr_addr_valid), .wr_addr(wr_addr),
  .rd_addr_valid(rd_addr_valid), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
  .err_vec(err_vec)
);

// File: tb/test_circbuf_addr_gen.sv
`timescale 1ns/1ps
module test_circbuf_addr_gen;
  localparam int NF = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [8:0] cfg_base = '0;
  logic [3:0] cfg_log2 = '0;
  logic [1:0] req_sel = '0;
  logic       wr_req = 1'b0;
  logic       rd_req = 1'b0;
  logic [7:0] tap_off_a = '0;
  logic [7:0] tap_off_b = '0;
  logic       wr_addr_valid, rd_addr_valid;
  logic [8:0] wr_addr, rd_addr_a, rd_addr_b;
  logic [NF-1:0] err_vec;

  always #10 clk = ~clk;

  circbuf_addr_gen i_circbuf_addr_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
    .cfg_log2(cfg_log2), .req_sel(req_sel), .wr_req(wr_req), .rd_req(rd_req),
    .tap_off_a(tap_off_a), .tap_off_b(tap_off_b), .wr_addr_valid(wr_addr_valid),
    .wr_addr(wr_addr), .rd_addr_valid(rd_addr_valid), .rd_addr_a(rd_addr_a),
    .rd_addr_b(rd_addr_b), .err_vec(err_vec)
  );

  typedef struct {
    string    tag;
    bit       wv;
    bit [8:0] wa;
    bit       rv;
    bit [8:0] ra;
    bit [8:0] rb;
    bit [NF-1:0] err;
  } item_t;

  item_t exp_q[$];
  int    n_vec = 0;
  int    n_bad = 0;

  // independent model of the region state
  int m_base [NF];
  int m_log2 [NF];
  int m_wp   [NF];
  bit m_err  [NF];

  function automatic int region_addr(int f, int ptr);
    int len = 1 << m_log2[f];
    return m_base[f] + (((ptr % 256) + 256) % 256) % len;
  endfunction

  task automatic cycle(input string tag, input bit cw, input int cs, input int cb,
                       input int cl, input int rs, input bit w, input bit r,
                       input int oa, input int ob);
    item_t it;
    @(negedge clk);
    cfg_we = cw; cfg_sel = 2'(cs); cfg_base = 9'(cb); cfg_log2 = 4'(cl);
    req_sel = 2'(rs); wr_req = w; rd_req = r; tap_off_a = 8'(oa); tap_off_b = 8'(ob);
    it.tag = tag;
    it.wv = w && !m_err[rs];
    it.rv = r && !m_err[rs];
    it.wa = 9'(region_addr(rs, m_wp[rs]));
    it.ra = 9'(region_addr(rs, m_wp[rs] - oa));
    it.rb = 9'(region_addr(rs, m_wp[rs] - ob));
    if (it.wv) m_wp[rs] = (m_wp[rs] + 1) % 256;
    if (cw) begin
      m_base[cs] = cb; m_log2[cs] = cl; m_wp[cs] = 0;
      m_err[cs] = (cl > 8) || (cb + (1 << cl) > 384);
    end
    it.err = '0;
    for (int f = 0; f < NF; f++) it.err[f] = m_err[f];
    exp_q.push_back(it);
  endtask

  task automatic cfg(input string tag, input int f, input int b, input int l);
    cycle(tag, 1'b1, f, b, l, 0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic idle(input string tag);
    cycle(tag, 1'b0, 0, 0, 0, 0, 1'b0, 1'b0, 0, 0);
  endtask

  // monitor: compares each cycle's registered outputs with the queued expectation
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      item_t e;
      bit bad;
      e = exp_q.pop_front();
      bad = 1'b0;
      n_vec++;
      if (wr_addr_valid !== e.wv || (e.wv && wr_addr !== e.wa)) begin
        bad = 1'b1;
        $display("FAIL %s write: got v=%0b a=%0d expected v=%0b a=%0d", e.tag, wr_addr_valid, wr_addr, e.wv, e.wa);
      end
      if (rd_addr_valid !== e.rv || (e.rv && (rd_addr_a !== e.ra || rd_addr_b !== e.rb))) begin
        bad = 1'b1;
        $display("FAIL %s read: got v=%0b a=%0d b=%0d expected v=%0b a=%0d b=%0d", e.tag, rd_addr_valid, rd_addr_a, rd_addr_b, e.rv, e.ra, e.rb);
      end
      if (err_vec !== e.err) begin
        bad = 1'b1;
        $display("FAIL %s err_vec: got %b expected %b", e.tag, err_vec, e.err);
      end
      if (bad) n_bad++;
    end
  end

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int f = 0; f < NF; f++) begin
      m_base[f] = 0; m_log2[f] = 0; m_wp[f] = 0; m_err[f] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle("R1 reset state");
    // R1: pointer 0 and base 0 after reset: first write of filter 2 lands at 0
    cycle("R1 first write after reset", 1'b0, 0, 0, 0, 2, 1'b1, 1'b0, 0, 0);
    cfg("R8 cfg f0", 0, 0, 3);
    cfg("R8 cfg f1", 1, 8, 2);
    cfg("R8 cfg f2", 2, 128, 8);
    cfg("R8 cfg f3", 3, 383, 0);
    // R2 / R3: ten writes into an 8-word region wrap back to base
    for (int i = 0; i < 10; i++) cycle("R2 R3 write wrap f0", 1'b0, 0, 0, 0, 0, 1'b1, 1'b0, 0, 0);
    // R4 / R5: newest, oldest and over-range offsets on two ports
    cycle("R4 R5 taps 1/8", 1'b0, 0, 0, 0, 0, 1'b0, 1'b1, 1, 8);
    cycle("R4 R5 taps 9/3", 1'b0, 0, 0, 0, 0, 1'b0, 1'b1, 9, 3);
    cycle("R4 tap 0/255", 1'b0, 0, 0, 0, 0, 1'b0, 1'b1, 0, 255);
    // R6: write and read together use the pre-write pointer
    cycle("R6 wr+rd f0", 1'b0, 0, 0, 0, 0, 1'b1, 1'b1, 1, 2);
    cycle("R6 after wr", 1'b0, 0, 0, 0, 0, 1'b0, 1'b1, 1, 2);
    // R7: interleaved filters keep separate pointers
    cycle("R7 f1 wr", 1'b0, 0, 0, 0, 1, 1'b1, 1'b0, 0, 0);
    cycle("R7 f1 wr", 1'b0, 0, 0, 0, 1, 1'b1, 1'b0, 0, 0);
    cycle("R7 f0 rd", 1'b0, 0, 0, 0, 0, 1'b0, 1'b1, 1, 5);
    cycle("R7 f1 wr+rd", 1'b0, 0, 0, 0, 1, 1'b1, 1'b1, 1, 6);
    // R11: length-1 region always returns its base
    cycle("R11 f3 wr", 1'b0, 0, 0, 0, 3, 1'b1, 1'b1, 1, 7);
    cycle("R11 f3 wr", 1'b0, 0, 0, 0, 3, 1'b1, 1'b1, 200, 0);
    // R12: full 256-word region up to the last memory word
    for (int i = 0; i < 256; i++) cycle("R12 f2 sweep", 1'b0, 0, 0, 0, 2, 1'b1, 1'b0, 0, 0);
    cycle("R12 f2 taps", 1'b0, 0, 0, 0, 2, 1'b0, 1'b1, 1, 255);
    cfg("R12 shifted region flagged", 2, 129, 8);
    // R9 / R10: bad geometry flagged, flagged filter not served
    cfg("R9 overflow f1", 1, 300, 7);
    cycle("R10 f1 wr blocked", 1'b0, 0, 0, 0, 1, 1'b1, 1'b1, 1, 2);
    cfg("R9 exp too large f1", 1, 0, 9);
    cycle("R10 f1 still blocked", 1'b0, 0, 0, 0, 1, 1'b1, 1'b0, 0, 0);
    cfg("R9 valid f1 clears", 1, 256, 7);
    cycle("R8 f1 pointer cleared", 1'b0, 0, 0, 0, 1, 1'b1, 1'b0, 0, 0);
    cycle("R8 f1 next", 1'b0, 0, 0, 0, 1, 1'b1, 1'b1, 1, 128);
    cycle("R10 f2 blocked", 1'b0, 0, 0, 0, 2, 1'b1, 1'b1, 1, 1);
    // R8: config and write to the same filter in one cycle
    cycle("R8 cfg+wr f0", 1'b1, 0, 64, 4, 0, 1'b1, 1'b0, 0, 0);
    cycle("R8 f0 new base", 1'b0, 0, 0, 0, 0, 1'b1, 1'b1, 1, 16);
    idle("R1 idle tail");
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule